// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to the retire stage of a small processor and runs the hardware part of entering an interrupt handler. It handles three sources: timer, disk and console. Each source has a sticky pending flag. It may start an entry only when an instruction retires while the machine runs unprivileged. A return from the handler can also start an entry, as described under retry below.

An entry has four steps. First it bumps the stack pointer and stores the current instruction pointer at the new top of stack. Next it reads the handler address from the ROM vector slot that belongs to the chosen source. It then loads that address into the instruction pointer. Finally it switches the machine to privileged mode with address translation off.

Before the push, the incremented stack pointer is checked against the length bound from the page table register. If it is outside that bound, the entry is abandoned and an illegal-memory-access pulse is raised. The block then re-runs the same entry at once on the next return to unprivileged mode.

Top module: `intr_entry_seq`

## Requirements
- R1: An entry starts (busy goes high one cycle later) only when `retireValid` is high, `privMode` is low and at least one pending flag is set. A retire while privileged, or a retire with nothing pending, starts nothing.
- R2: In the first cycle of an entry, `stackWrEn` and `spLoad` are high, `stackWrAddr` and `spNext` equal `spIn`+1, and `stackWrData` equals `ipIn`.
- R3: Pending bit 0 is the timer, bit 1 the disk and bit 2 the console. The lowest set bit wins. In the push cycle the ROM is read at `VEC_BASE`+index, which is 493, 494 or 495 by default.
- R4: The ROM word that arrives one cycle after the read is driven on `ipNext` with `ipLoad` high, three cycles after the start edge.
- R5: In the cycle after `ipLoad`, `privMode` is 1, `xlateEn` is 0 and `busy` is 0.
- R6: A pulse on `irqSet` sets the matching pending bit. When an entry completes, only the chosen bit is cleared.
- R7: If `spIn`+1 ≥ `ptlr`×`PAGE_WORDS`, the push cycle raises `illegalAccess` and performs no stack write and no ROM read. In the next cycle `privMode`=1, `xlateEn`=0 and busy is low, and the pending flags are unchanged.
- R8: After an abort, a `rtiDone` pulse starts the same entry on the next edge without any retire. The push appears one cycle after the pulse, with the machine unprivileged.
- R9: A `rtiDone` pulse while privileged and idle gives `privMode`=0 and `xlateEn`=1 from the next cycle.
- R10: `busy` is high for exactly the three cycles of a completed entry: push, vector read and switch.
- R11: After reset, `busy`=0, `privMode`=1, `xlateEn`=0, pending=0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retired this cycle |
| rtiDone | input | 1 | Return-from-interrupt completed this cycle |
| irqSet | input | 3 | Per-source set pulses (timer, disk, console) |
| ipIn | input | W | Current instruction pointer |
| spIn | input | W | Current stack pointer |
| ptlr | input | PTLR_W | Page table length, in pages |
| romRdData | input | W | ROM read data, one cycle after the read |
| busy | output | 1 | Entry in progress; stalls fetch |
| pending | output | 3 | Pending flags |
| stackWrEn | output | 1 | Stack write strobe |
| stackWrAddr | output | W | Stack write address (new top of stack) |
| stackWrData | output | W | Stack write data (saved IP) |
| spLoad | output | 1 | Stack pointer update strobe |
| spNext | output | W | New stack pointer |
| romRdEn | output | 1 | Vector ROM read strobe |
| romRdAddr | output | W | Vector slot address |
| ipLoad | output | 1 | Instruction pointer load strobe |
| ipNext | output | W | Handler address |
| privMode | output | 1 | Privileged mode |
| xlateEn | output | 1 | Address translation enabled |
| illegalAccess | output | 1 | Illegal-memory-access exception pulse |

## Verification
Counting from the edge that samples the retire, the push and the fault pulse are due one cycle later and the handler load three cycles later. The mode change shows one cycle after the handler load; on a retry the push follows the return pulse by one cycle. The bench records each expected push, load or fault together with the cycle it is due in a queue. A monitor reads the outputs at the falling edge and matches every strobe it sees to the head of the queue by kind, cycle and value. It flags any expected item whose cycle has passed as missing. Busy, mode and pending flags are checked at the falling edge of the exact cycle counted from the drive edge.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W = $clog2(NUM_SRC);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VREAD, ST_SWITCH} seqStateT;

  typedef struct packed {
    logic latchSel;
    logic latchRetry;
    logic pushTry;
    logic grabVec;
    logic commit;
    logic leavePriv;
  } seqCmdT;

  typedef struct packed {
    logic anyPend;
    logic spFault;
    logic privQ;
    logic retryArm;
  } seqStatT;

  // lowest index has highest priority
  function automatic logic [SRC_W-1:0] pickSrc(input logic [NUM_SRC-1:0] p);
    pickSrc = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (p[i]) pickSrc = SRC_W'(i);
    end
  endfunction
endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    retireValid,
  input  logic    rtiDone,
  input  seqStatT stat,
  output seqCmdT  cmd,
  output logic    busy
);
  seqStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        cmd.leavePriv = rtiDone && stat.privQ;
        if (rtiDone && stat.privQ && stat.retryArm) begin
          cmd.latchRetry = 1'b1;
          stateNext = ST_PUSH;
        end else if (retireValid && !stat.privQ && stat.anyPend) begin
          cmd.latchSel = 1'b1;
          stateNext = ST_PUSH;
        end
      end
      ST_PUSH: begin
        cmd.pushTry = 1'b1;
        stateNext = stat.spFault ? ST_IDLE : ST_VREAD;
      end
      ST_VREAD: begin
        cmd.grabVec = 1'b1;
        stateNext = ST_SWITCH;
      end
      ST_SWITCH: begin
        cmd.commit = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  assert_enter_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && retireValid && !stat.privQ && stat.anyPend) |=> busy);

  assert_priv_no_entry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stat.privQ && !(rtiDone && stat.retryArm)) |=> !busy);

  assert_retry_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rtiDone && stat.privQ && stat.retryArm) |=> (busy && !stat.privQ));
endmodule

// File: rtl/intr_entry_dp.sv
module intr_entry_dp
  import intr_entry_pkg::*;
#(
  parameter int W          = 16,
  parameter int PTLR_W     = 8,
  parameter int PAGE_WORDS = 512,
  parameter int VEC_BASE   = 493
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmdT             cmd,
  input  logic [NUM_SRC-1:0] irqSet,
  input  logic [W-1:0]       ipIn,
  input  logic [W-1:0]       spIn,
  input  logic [PTLR_W-1:0]  ptlr,
  input  logic [W-1:0]       romRdData,
  output seqStatT            stat,
  output logic [NUM_SRC-1:0] pending,
  output logic               stackWrEn,
  output logic [W-1:0]       stackWrAddr,
  output logic [W-1:0]       stackWrData,
  output logic               spLoad,
  output logic [W-1:0]       spNext,
  output logic               romRdEn,
  output logic [W-1:0]       romRdAddr,
  output logic               ipLoad,
  output logic [W-1:0]       ipNext,
  output logic               privMode,
  output logic               xlateEn,
  output logic               illegalAccess
);
  localparam int PG_SH = $clog2(PAGE_WORDS);
  localparam int LIM_W = PTLR_W + PG_SH;
  localparam int CMP_W = ((W > LIM_W) ? W : LIM_W) + 1;

  logic [NUM_SRC-1:0] pendQ, clrMask;
  logic [SRC_W-1:0]   selQ;
  logic [W-1:0]       vecQ;
  logic               privQ, retryArmQ;
  logic [CMP_W-1:0]   spIncW, limitW;
  logic               spFault, pushOk, abortNow;

  // widened so the increment never wraps into the legal range
  assign spIncW   = CMP_W'(spIn) + CMP_W'(1);
  assign limitW   = CMP_W'(ptlr) << PG_SH;
  assign spFault  = (spIncW >= limitW);
  assign pushOk   = cmd.pushTry && !spFault;
  assign abortNow = cmd.pushTry && spFault;

  always_comb begin
    clrMask = '0;
    if (cmd.commit) clrMask[selQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= '0;
      selQ      <= '0;
      vecQ      <= '0;
      privQ     <= 1'b1;
      retryArmQ <= 1'b0;
    end else begin
      pendQ <= (pendQ & ~clrMask) | irqSet;
      if (cmd.latchSel) selQ <= pickSrc(pendQ);
      if (cmd.grabVec)  vecQ <= romRdData;
      if (abortNow || cmd.commit) privQ <= 1'b1;
      else if (cmd.leavePriv)     privQ <= 1'b0;
      if (abortNow)            retryArmQ <= 1'b1;
      else if (cmd.latchRetry) retryArmQ <= 1'b0;
    end
  end

  assign stat.anyPend  = |pendQ;
  assign stat.spFault  = spFault;
  assign stat.privQ    = privQ;
  assign stat.retryArm = retryArmQ;

  assign pending       = pendQ;
  assign stackWrEn     = pushOk;
  assign stackWrAddr   = spIncW[W-1:0];
  assign stackWrData   = ipIn;
  assign spLoad        = pushOk;
  assign spNext        = spIncW[W-1:0];
  assign romRdEn       = pushOk;
  assign romRdAddr     = W'(VEC_BASE) + W'(selQ);
  assign ipLoad        = cmd.commit;
  assign ipNext        = vecQ;
  assign privMode      = privQ;
  assign xlateEn       = !privQ;
  assign illegalAccess = abortNow;

  assert_vec_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> (romRdAddr >= W'(VEC_BASE) && romRdAddr < W'(VEC_BASE + NUM_SRC)));

  assert_vec_to_ip_R4: assert property (@(posedge clk) disable iff (!rstN)
    ipLoad |-> $past(romRdEn, 2));

  assert_mode_after_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    ipLoad |=> (privMode && !xlateEn));

  assert_clear_chosen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ipLoad && !irqSet[selQ]) |=> !pending[$past(selQ)]);

  assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalAccess |-> (!stackWrEn && !romRdEn));

  assert_fault_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalAccess |=> (privMode && stat.retryArm && pending == ($past(pending) | $past(irqSet))));
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int W          = 16,
  parameter int PTLR_W     = 8,
  parameter int PAGE_WORDS = 512,
  parameter int VEC_BASE   = 493
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retireValid,
  input  logic               rtiDone,
  input  logic [NUM_SRC-1:0] irqSet,
  input  logic [W-1:0]       ipIn,
  input  logic [W-1:0]       spIn,
  input  logic [PTLR_W-1:0]  ptlr,
  input  logic [W-1:0]       romRdData,
  output logic               busy,
  output logic [NUM_SRC-1:0] pending,
  output logic               stackWrEn,
  output logic [W-1:0]       stackWrAddr,
  output logic [W-1:0]       stackWrData,
  output logic               spLoad,
  output logic [W-1:0]       spNext,
  output logic               romRdEn,
  output logic [W-1:0]       romRdAddr,
  output logic               ipLoad,
  output logic [W-1:0]       ipNext,
  output logic               privMode,
  output logic               xlateEn,
  output logic               illegalAccess
);
  seqCmdT  cmd;
  seqStatT stat;

  intr_entry_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .rtiDone(rtiDone),
    .stat(stat), .cmd(cmd), .busy(busy)
  );

  intr_entry_dp #(.W(W), .PTLR_W(PTLR_W), .PAGE_WORDS(PAGE_WORDS), .VEC_BASE(VEC_BASE)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .irqSet(irqSet), .ipIn(ipIn), .spIn(spIn),
    .ptlr(ptlr), .romRdData(romRdData), .stat(stat), .pending(pending),
    .stackWrEn(stackWrEn), .stackWrAddr(stackWrAddr), .stackWrData(stackWrData),
    .spLoad(spLoad), .spNext(spNext), .romRdEn(romRdEn), .romRdAddr(romRdAddr),
    .ipLoad(ipLoad), .ipNext(ipNext), .privMode(privMode), .xlateEn(xlateEn),
    .illegalAccess(illegalAccess)
  );
endmodule

// File: tb/tb_intr_entry_seq.sv
`timescale 1ns/1ps
module tb_intr_entry_seq;
  localparam int W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, retireValid, rtiDone;
  logic [2:0] irqSet, pending;
  logic [W-1:0] ipIn, spIn, romRdData, stackWrAddr, stackWrData, spNext, romRdAddr, ipNext;
  logic [7:0] ptlr;
  logic busy, stackWrEn, spLoad, romRdEn, ipLoad, privMode, xlateEn, illegalAccess;

  intr_entry_seq dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .rtiDone(rtiDone), .irqSet(irqSet),
    .ipIn(ipIn), .spIn(spIn), .ptlr(ptlr), .romRdData(romRdData), .busy(busy),
    .pending(pending), .stackWrEn(stackWrEn), .stackWrAddr(stackWrAddr),
    .stackWrData(stackWrData), .spLoad(spLoad), .spNext(spNext), .romRdEn(romRdEn),
    .romRdAddr(romRdAddr), .ipLoad(ipLoad), .ipNext(ipNext), .privMode(privMode),
    .xlateEn(xlateEn), .illegalAccess(illegalAccess)
  );

  // vector ROM model with one cycle of read latency
  always @(posedge clk) begin
    if (romRdEn)
      romRdData <= (romRdAddr == 16'd493) ? 16'd2048 :
                   (romRdAddr == 16'd494) ? 16'd3072 :
                   (romRdAddr == 16'd495) ? 16'd4096 : 16'hDEAD;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int cyc; int kind; int a; int b; int c; string req;} expT;
  expT expQ[$];
  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic popCmp(input int kind, input int a, input int b, input int c);
    expT e;
    if (expQ.size() == 0) begin
      chk(0, "R1", $sformatf("unexpected event kind %0d at cycle", kind), cyc, -1);
    end else begin
      e = expQ.pop_front();
      chk(e.kind == kind, e.req, "event kind", kind, e.kind);
      chk(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
      chk(e.a == a, e.req, "event value", a, e.a);
      if (kind == 0) begin
        chk(e.b == b, e.req, "pushed data", b, e.b);
        chk(e.c == c, "R3", "vector slot address", c, e.c);
      end
    end
  endtask

  // monitor: compares produced strobes with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (stackWrEn) begin
        popCmp(0, int'(stackWrAddr), int'(stackWrData), int'(romRdAddr));
        chk(spLoad && spNext == stackWrAddr, "R2", "sp update", int'(spNext), int'(stackWrAddr));
      end
      if (ipLoad) popCmp(1, int'(ipNext), 0, 0);
      if (illegalAccess) popCmp(2, 0, 0, 0);
      while (expQ.size() != 0 && expQ[0].cyc < cyc) begin
        chk(0, expQ[0].req, "missing event due cycle", cyc, expQ[0].cyc);
        void'(expQ.pop_front());
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rti();
    tick(); rtiDone = 1;
    tick(); rtiDone = 0;
    @(negedge clk);
    chk(privMode == 0, "R9", "privMode after return", privMode, 0);
    chk(xlateEn == 1, "R9", "xlateEn after return", xlateEn, 1);
  endtask

  task automatic raise(input logic [2:0] bits, input logic [2:0] expPend);
    tick(); irqSet = bits;
    tick(); irqSet = 3'b000;
    @(negedge clk);
    chk(pending == expPend, "R6", "pending after set", pending, expPend);
  endtask

  task automatic noEntry(input string req);
    tick(); retireValid = 1;
    tick(); retireValid = 0;
    @(negedge clk);
    chk(busy == 0, req, "busy with no entry allowed", busy, 0);
  endtask

  task automatic take(input int spv, input int ipv, input int handler, input int romA, input logic [2:0] pendAfter);
    tick();
    spIn = W'(spv); ipIn = W'(ipv); retireValid = 1;
    expQ.push_back('{cyc + 1, 0, spv + 1, ipv, romA, "R2"});
    expQ.push_back('{cyc + 3, 1, handler, 0, 0, "R4"});
    for (int i = 1; i <= 4; i++) begin
      tick(); retireValid = 0;
      @(negedge clk);
      chk(busy == (i <= 3), "R10", $sformatf("busy in entry cycle %0d", i), busy, (i <= 3));
    end
    chk(privMode == 1, "R5", "privMode after load", privMode, 1);
    chk(xlateEn == 0, "R5", "xlateEn after load", xlateEn, 0);
    chk(pending == pendAfter, "R6", "pending after entry", pending, pendAfter);
  endtask

  initial begin
    rstN = 0; retireValid = 0; rtiDone = 0; irqSet = 0;
    ipIn = 0; spIn = 0; ptlr = 8'd4;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(busy == 0, "R11", "busy after reset", busy, 0);
    chk(privMode == 1, "R11", "privMode after reset", privMode, 1);
    chk(xlateEn == 0, "R11", "xlateEn after reset", xlateEn, 0);
    chk(pending == 0, "R11", "pending after reset", pending, 0);
    chk(!stackWrEn && !ipLoad && !illegalAccess, "R11", "strobes after reset", stackWrEn, 0);

    rti();
    noEntry("R1");                         // nothing pending
    raise(3'b010, 3'b010);
    take(200, 16'h0123, 3072, 494, 3'b000); // disk
    raise(3'b100, 3'b100);
    noEntry("R1");                         // privileged retire
    chk(pending == 3'b100, "R1", "pending kept while privileged", pending, 3'b100);
    rti();
    take(201, 16'h0200, 4096, 495, 3'b000); // console
    rti();
    raise(3'b101, 3'b101);
    take(300, 16'h0300, 2048, 493, 3'b100); // R3 timer beats console
    rti();
    take(301, 16'h0301, 4096, 495, 3'b000);

    // R7 boundary: one page, top legal slot is 511
    ptlr = 8'd1;
    rti();
    raise(3'b010, 3'b010);
    take(510, 16'h0400, 3072, 494, 3'b000);
    rti();
    raise(3'b010, 3'b010);
    tick();
    spIn = 16'd511; ipIn = 16'h0500; retireValid = 1;
    expQ.push_back('{cyc + 1, 2, 0, 0, 0, "R7"});
    tick(); retireValid = 0;
    @(negedge clk);
    chk(busy == 1, "R7", "busy in push cycle", busy, 1);
    tick();
    @(negedge clk);
    chk(busy == 0, "R7", "busy after abort", busy, 0);
    chk(privMode == 1 && xlateEn == 0, "R7", "mode after abort", privMode, 1);
    chk(pending == 3'b010, "R7", "pending kept after abort", pending, 3'b010);

    // R8 retry on return, no retire needed
    tick();
    spIn = 16'd100; rtiDone = 1;
    expQ.push_back('{cyc + 1, 0, 101, 16'h0500, 494, "R8"});
    expQ.push_back('{cyc + 3, 1, 3072, 0, 0, "R8"});
    tick(); rtiDone = 0;
    @(negedge clk);
    chk(busy == 1 && privMode == 0, "R8", "retry running unprivileged", busy, 1);
    repeat (3) tick();
    @(negedge clk);
    chk(privMode == 1, "R8", "privMode after retry", privMode, 1);
    chk(pending == 3'b000, "R8", "pending after retry", pending, 0);

    repeat (3) tick();
    @(negedge clk);
    chk(expQ.size() == 0, "R4", "scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule